// File: doc/BRIEF.md
# DDR4 Command Sequencer with Per-Bank Row Tracking

This block turns single user read or write requests into DDR4 command-bus cycles. Each request names a bank group, a bank, an 18-bit row, a 10-bit column, a burst-chop choice and an auto-precharge choice. The sequencer records which row is open in each of the 16 banks. From that record it classifies every request into one of three cases:

- a row hit, which needs only the column command;
- an idle bank, which needs an ACTIVATE and then the column command;
- a row conflict, which needs a PRECHARGE, an ACTIVATE and then the column command.

The block puts at most one command on the pins per clock. During an ACTIVATE, the RAS/CAS/WE pins carry high row-address bits instead of command meanings.

Requests enter through a valid/ready handshake. A request is accepted on a clock edge where both are high. Its commands then occupy the following consecutive cycles, one per cycle. The block takes no new request until the column command of the current one has gone out. Data capture, interface timing, refresh and request reordering are handled elsewhere.

Top module: `cmd_sequencer`

## Requirements
- R1: After reset, `reqReady` is high, the pins show the no-operation pattern of R3, and every bank counts as closed.
- R2: `reqReady` is high only when no request is in progress. After an accept it stays low until the cycle after the request's READ or WRITE cycle, and in that cycle it is high again.
- R3: Exactly one command or a no-operation appears per clock. The no-operation pattern is: `csN`, `actN`, `rasN`, `casN` and `weN` all high, `addrLo` = 0, `addrA17` = 0, `bg` = 0 and `ba` = 0.
- R4: An ACTIVATE drives `csN` = 0 and `actN` = 0. `{rasN, casN, weN}` carry row bits 16, 15 and 14. `addrLo` carries row bits 13:0 and `addrA17` carries row bit 17. `bg` and `ba` carry the bank.
- R5: A column command drives `csN` = 0 and `actN` = 1, with `{rasN, casN, weN}` = 101 for READ and 100 for WRITE. `addrLo[9:0]` is the column and `addrLo[10]` is the auto-precharge flag. `addrLo[12]` is low when burst chop (4 transfers) is requested and high for a burst of 8. `addrLo[11]`, `addrLo[13]` and `addrA17` are 0.
- R6: A PRECHARGE drives `csN` = 0, `actN` = 1 and `{rasN, casN, weN}` = 010, with `addrLo` = 0 (single-bank close) and `addrA17` = 0. It carries the target bank on `bg` and `ba`.
- R7: A request to a closed bank produces an ACTIVATE in the cycle after acceptance, followed by the column command in the next cycle.
- R8: A request to the row already open in its bank produces the column command in the cycle after acceptance, with no ACTIVATE.
- R9: A request to a bank holding a different open row produces PRECHARGE, ACTIVATE and the column command in three consecutive cycles, starting the cycle after acceptance.
- R10: A column command with auto-precharge leaves its bank closed, so the next request to that bank follows R7.
- R11: The 16 banks hold their open rows independently. Activity in one bank never changes how another bank's requests are classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBg | input | 2 | Bank group |
| reqBa | input | 2 | Bank within the group |
| reqRow | input | 18 | Row address |
| reqCol | input | 10 | Starting column |
| reqChop | input | 1 | 1 = chop the burst to 4 transfers |
| reqAutoPre | input | 1 | 1 = close the row after the access |
| csN | output | 1 | Chip select, active low |
| actN | output | 1 | Activate marker, active low |
| rasN | output | 1 | Row strobe, or row bit 16 during ACTIVATE |
| casN | output | 1 | Column strobe, or row bit 15 during ACTIVATE |
| weN | output | 1 | Write enable, or row bit 14 during ACTIVATE |
| addrLo | output | 14 | Address pins A13..A0 |
| addrA17 | output | 1 | Address pin A17 |
| bg | output | 2 | Bank group pins |
| ba | output | 2 | Bank address pins |

## Verification
A wrong entry in the open-row table shows up at the pins in the first cycle after the next request to that bank is accepted. A lost entry appears as an ACTIVATE where a column command was due. A stale entry appears as a column command where a PRECHARGE was due. A wrong row value turns a hit into a conflict or the reverse.

Every bank is swept through the closed, hit, conflict and auto-precharge-closed cases. The bench keeps its own table of open rows and checks the whole pin vector in every command cycle. Any classification or encoding error is therefore caught within one to three cycles of the faulty request's acceptance.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_ACT, CMD_RW} cmdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    cmdKind_e cmd;
  } seqStrobe_t;

  // bank-table lookup from datapath to control
  typedef struct packed {
    logic bankOpen;
    logic rowMatch;
  } bankLook_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import cmd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  bankLook_t  look,
  output logic       reqReady,
  output seqStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_RW} state_e;
  state_e state, stateNext;
  logic accept;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (accept) begin
        if (!look.bankOpen)     stateNext = S_ACT;
        else if (look.rowMatch) stateNext = S_RW;
        else                    stateNext = S_PRE;
      end
      S_PRE:   stateNext = S_ACT;
      S_ACT:   stateNext = S_RW;
      S_RW:    stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.latchReq = accept;
    unique case (state)
      S_PRE:   strobe.cmd = CMD_PRE;
      S_ACT:   strobe.cmd = CMD_ACT;
      S_RW:    strobe.cmd = CMD_RW;
      default: strobe.cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/seq_bank_path.sv
module seq_bank_path
  import cmd_seq_pkg::*;
#(
  parameter int ROW_W = 18,
  parameter int COL_W = 10,
  parameter int BG_W  = 2,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             reqWrite,
  input  logic [BG_W-1:0]  reqBg,
  input  logic [BA_W-1:0]  reqBa,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             reqChop,
  input  logic             reqAutoPre,
  output bankLook_t        look,
  output logic             csN,
  output logic             actN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [13:0]      addrLo,
  output logic             addrA17,
  output logic [BG_W-1:0]  bg,
  output logic [BA_W-1:0]  ba
);
  localparam int BANK_W = BG_W + BA_W;
  localparam int NBANK  = 1 << BANK_W;
  localparam int AP_BIT = 10;
  localparam int BC_BIT = 12;

  logic [BANK_W-1:0] curBank;
  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic              curWrite, curChop, curAp;

  logic [NBANK-1:0]  openValid;
  logic [ROW_W-1:0]  openRow [NBANK];
  logic [BANK_W-1:0] lookBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBank <= '0; curRow <= '0; curCol <= '0;
      curWrite <= 1'b0; curChop <= 1'b0; curAp <= 1'b0;
    end else if (strobe.latchReq) begin
      curBank  <= {reqBg, reqBa};
      curRow   <= reqRow;
      curCol   <= reqCol;
      curWrite <= reqWrite;
      curChop  <= reqChop;
      curAp    <= reqAutoPre;
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic mine;
    assign mine = (curBank == BANK_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openValid[i] <= 1'b0;
        openRow[i]   <= '0;
      end else if (mine) begin
        unique case (strobe.cmd)
          CMD_ACT: begin openValid[i] <= 1'b1; openRow[i] <= curRow; end
          CMD_PRE: openValid[i] <= 1'b0;
          CMD_RW:  if (curAp) openValid[i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign lookBank      = {reqBg, reqBa};
  assign look.bankOpen = openValid[lookBank];
  assign look.rowMatch = (openRow[lookBank] == reqRow);

  always_comb begin
    csN = 1'b1; actN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    addrLo = '0; addrA17 = 1'b0; bg = '0; ba = '0;
    unique case (strobe.cmd)
      CMD_ACT: begin
        csN = 1'b0; actN = 1'b0;
        {rasN, casN, weN} = curRow[16:14];
        addrLo  = curRow[13:0];
        addrA17 = curRow[17];
        {bg, ba} = curBank;
      end
      CMD_PRE: begin
        csN = 1'b0;
        {rasN, casN, weN} = 3'b010;
        {bg, ba} = curBank;
      end
      CMD_RW: begin
        csN = 1'b0;
        {rasN, casN, weN} = {2'b10, ~curWrite};
        addrLo[COL_W-1:0] = curCol;
        addrLo[AP_BIT]    = curAp;
        addrLo[BC_BIT]    = ~curChop;
        {bg, ba} = curBank;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import cmd_seq_pkg::*;
#(
  parameter int ROW_W = 18,
  parameter int COL_W = 10,
  parameter int BG_W  = 2,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [BG_W-1:0]  reqBg,
  input  logic [BA_W-1:0]  reqBa,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             reqChop,
  input  logic             reqAutoPre,
  output logic             csN,
  output logic             actN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [13:0]      addrLo,
  output logic             addrA17,
  output logic [BG_W-1:0]  bg,
  output logic [BA_W-1:0]  ba
);
  seqStrobe_t strobe;
  bankLook_t  look;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .look(look),
    .reqReady(reqReady), .strobe(strobe)
  );

  seq_bank_path #(.ROW_W(ROW_W), .COL_W(COL_W), .BG_W(BG_W), .BA_W(BA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqBg(reqBg), .reqBa(reqBa), .reqRow(reqRow),
    .reqCol(reqCol), .reqChop(reqChop), .reqAutoPre(reqAutoPre),
    .look(look),
    .csN(csN), .actN(actN), .rasN(rasN), .casN(casN), .weN(weN),
    .addrLo(addrLo), .addrA17(addrA17), .bg(bg), .ba(ba)
  );
endmodule

// File: rtl/cmd_sequencer_chk.sv
module cmd_sequencer_chk #(
  parameter int BG_W = 2,
  parameter int BA_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            csN,
  input logic            actN,
  input logic            rasN,
  input logic            casN,
  input logic            weN,
  input logic [13:0]     addrLo,
  input logic            addrA17,
  input logic [BG_W-1:0] bg,
  input logic [BA_W-1:0] ba
);
  logic isAct, isPre, isCol;
  assign isAct = !csN && !actN;
  assign isPre = !csN && actN && !rasN && casN && !weN;
  assign isCol = !csN && actN && rasN && !casN;

  // R2: an accepted request makes the block busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R2: ready returns right after the column command
  a_r2_ready_after_col: assert property (@(posedge clk) disable iff (!rstN)
    isCol |=> reqReady);

  // R3: deselected cycles show the quiet pin pattern
  a_r3_nop_pattern: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (actN && rasN && casN && weN && addrLo == '0 && !addrA17 && bg == '0 && ba == '0));

  // R3: no command while waiting for a request
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);

  // R7: an ACTIVATE is followed by a column command to the same bank
  a_r7_act_then_col: assert property (@(posedge clk) disable iff (!rstN)
    isAct |=> (isCol && bg == $past(bg) && ba == $past(ba)));

  // R9: a PRECHARGE is followed by an ACTIVATE of the same bank
  a_r9_pre_then_act: assert property (@(posedge clk) disable iff (!rstN)
    isPre |=> (isAct && bg == $past(bg) && ba == $past(ba)));
endmodule

bind cmd_sequencer cmd_sequencer_chk #(.BG_W(BG_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/tb_cmd_sequencer.sv
module tb_cmd_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqBg = '0;
  logic [1:0]  reqBa = '0;
  logic [17:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic        reqChop = 1'b0;
  logic        reqAutoPre = 1'b0;
  logic        csN, actN, rasN, casN, weN, addrA17;
  logic [13:0] addrLo;
  logic [1:0]  bg, ba;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic        refValid [16];
  logic [17:0] refRow [16];

  always #10 clk = ~clk;

  cmd_sequencer dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBg(reqBg), .reqBa(reqBa), .reqRow(reqRow),
    .reqCol(reqCol), .reqChop(reqChop), .reqAutoPre(reqAutoPre),
    .csN(csN), .actN(actN), .rasN(rasN), .casN(casN), .weN(weN),
    .addrLo(addrLo), .addrA17(addrA17), .bg(bg), .ba(ba)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // pin vector: {csN, actN, rasN, casN, weN, addrA17, addrLo, bg, ba}
  function automatic logic [23:0] pinsNow();
    return {csN, actN, rasN, casN, weN, addrA17, addrLo, bg, ba};
  endfunction

  function automatic logic [23:0] nopVec();
    return {5'b11111, 1'b0, 14'd0, 4'd0};
  endfunction

  function automatic logic [23:0] actVec(logic [3:0] bank, logic [17:0] row);
    return {2'b00, row[16], row[15], row[14], row[17], row[13:0], bank};
  endfunction

  function automatic logic [23:0] preVec(logic [3:0] bank);
    return {5'b01010, 1'b0, 14'd0, bank};
  endfunction

  function automatic logic [23:0] colVec(logic wr, logic [3:0] bank, logic [9:0] col,
                                         logic chop, logic ap);
    logic [13:0] a;
    a = {1'b0, ~chop, 1'b0, ap, col};
    return {4'b0110, ~wr, 1'b0, a, bank};
  endfunction

  task automatic checkPins(logic [23:0] exp, string tag);
    logic [23:0] got;
    got = pinsNow();
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pins got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkReady(logic exp, string tag);
    vectors++;
    if (reqReady !== exp) begin
      fails++;
      $display("FAIL %s: reqReady got %b expected %b", tag, reqReady, exp);
    end
  endtask

  // one request: apply, then follow its commands against the reference table
  task automatic access(logic wr, logic [3:0] bank, logic [17:0] row, logic [9:0] col,
                        logic chop, logic ap, string tag);
    @(negedge clk);
    checkReady(1'b1, "R2");
    reqValid = 1'b1; reqWrite = wr; {reqBg, reqBa} = bank; reqRow = row;
    reqCol = col; reqChop = chop; reqAutoPre = ap;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    checkReady(1'b0, "R2");
    if (!refValid[bank]) begin
      checkPins(actVec(bank, row), {tag, "/R7/R4"});
      @(negedge clk);
    end else if (refRow[bank] != row) begin
      checkPins(preVec(bank), {tag, "/R9/R6"});
      @(negedge clk);
      checkPins(actVec(bank, row), {tag, "/R9/R4"});
      @(negedge clk);
    end
    checkPins(colVec(wr, bank, col, chop, ap), {tag, "/R5"});
    checkReady(1'b0, "R2");
    refValid[bank] = !ap;
    refRow[bank]   = row;
    @(negedge clk);
    checkReady(1'b1, "R2");
    checkPins(nopVec(), "R3");
  endtask

  function automatic logic [17:0] rowA(int b);
    return 18'((b * 40961 + 3) & 32'h3FFFF);
  endfunction

  function automatic logic [17:0] rowB(int b);
    return rowA(b) ^ 18'h3C001;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin refValid[i] = 1'b0; refRow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkReady(1'b1, "R1");
    checkPins(nopVec(), "R1");
    @(negedge clk);
    checkPins(nopVec(), "R3");

    // closed banks after reset: ACTIVATE then column command
    for (int b = 0; b < 16; b++)
      access(b[0], 4'(b), rowA(b), 10'(b * 61), b[1], 1'b0, "R1");
    // same rows again: hits
    for (int b = 0; b < 16; b++)
      access(~b[0], 4'(b), rowA(b), 10'(1023 - b), ~b[1], 1'b0, "R8");
    // different rows with auto-precharge: conflicts
    for (int b = 0; b < 16; b++)
      access(b[2], 4'(b), rowB(b), 10'(b * 7 + 512), b[0], 1'b1, "R9");
    // after auto-precharge the bank is closed
    for (int b = 0; b < 16; b++)
      access(b[1], 4'(b), rowB(b), 10'(b), 1'b0, 1'b0, "R10");
    // extreme row patterns on alternating banks
    for (int b = 0; b < 16; b += 2)
      access(1'b1, 4'(b), 18'h3FFFF, 10'h3FF, 1'b1, 1'b0, "R4");
    for (int b = 0; b < 16; b += 2)
      access(1'b0, 4'(b), 18'h1C000, 10'h000, 1'b0, 1'b0, "R6");
    // untouched odd banks still hit their own rows
    for (int b = 1; b < 16; b += 2)
      access(1'b0, 4'(b), rowB(b), 10'(b * 3), 1'b1, 1'b0, "R11");
    // reverse-order cross-bank interleave
    for (int b = 15; b >= 0; b--)
      access(b[0], 4'(15 - b), rowA(b), 10'(b * 37), b[0], b[1], "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule